// File: doc/BRIEF.md
# Operand Staging Buffer with Stepping Pointers

This block stages operands and results between a processor register file and an attached custom compute unit. It has two register banks. The input bank is filled from the register file's read ports, `RD_PORTS` words per transfer. The output bank is drained towards the register file's write ports, `WR_PORTS` words per transfer. The processor never addresses either bank. Each bank has a hidden pointer that starts at zero and steps by its port count after every transfer. An operation can therefore take, or return, more words than the ports can carry in one instruction.

The compute unit sees the whole input bank at once on `cu_in_o`. On completion it delivers the whole output bank in parallel on `cu_out_i`. Each operation carries a latency, sampled when it starts, which sets when the result is captured.

There are two execute flavours:
- A blocking execute holds the processor on `stall_o` until the result is in. It then returns the first result word(s).
- A concurrent execute lets the processor run on. A later move-from request stalls only while the operation is still in flight.

Top module: `arg_xfer_buffer`

## Requirements
- R1: After reset, `stall_o`, `rd_valid_o`, `ovf_o` and `cu_start_o` are 0, every input bank entry on `cu_in_o` reads 0, and both pointers are 0.
- R2: A move-to writes word k of `mv_to_data_i` (bits [k*DATA_W +: DATA_W]) into input entry pointer+k, for k = 0 to `RD_PORTS`-1. It then advances the input pointer by `RD_PORTS`. Input entry i appears on `cu_in_o` bits [i*DATA_W +: DATA_W] from the following cycle.
- R3: An accepted execute writes its `RD_PORTS` source words at the current input pointer, in the same layout as a move-to. In that same cycle it sets both pointers back to 0.
- R4: An execute is accepted only when no operation is busy; one that arrives while busy changes nothing. After acceptance, `cu_start_o` is 1 for exactly the next cycle. The operation stays busy for `exec_lat_i`+1 cycles, and on the last of them the output bank captures `cu_out_i` (entry j from bits [j*DATA_W +: DATA_W]).
- R5: A blocking execute with latency L raises `stall_o` for exactly L+1 cycles. In the cycle after `stall_o` falls, `rd_valid_o` is 1 for one cycle, and `rd_data_o` holds output entries 0 to `WR_PORTS`-1. The output pointer then equals `WR_PORTS`.
- R6: A concurrent execute does not raise `stall_o` while no move-from is requested.
- R7: A move-from that meets an idle block yields, one cycle later, `rd_valid_o` and the `WR_PORTS` output entries starting at the output pointer, and advances the pointer by `WR_PORTS`. A move-from that meets a busy block holds `stall_o` high until the operation has finished, then completes in the same way.
- R8: A transfer that would reach past the last entry of its bank is dropped whole and leaves the pointer unchanged. A dropped move-from gives no `rd_valid_o`. Any such drop sets `ovf_o`, which stays 1 until reset. A transfer that ends exactly on the last entry is not a drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mv_to_i | input | 1 | Move-to request for one cycle |
| mv_to_data_i | input | RD_PORTS*DATA_W | Register file read values for a move-to |
| exec_blk_i | input | 1 | Blocking execute request |
| exec_cnc_i | input | 1 | Concurrent execute request |
| exec_src_i | input | RD_PORTS*DATA_W | Source values carried by an execute |
| exec_lat_i | input | LAT_W | Operation latency, sampled at acceptance |
| mv_from_i | input | 1 | Move-from request, held while stalled |
| rd_data_o | output | WR_PORTS*DATA_W | Words returned to the register file |
| rd_valid_o | output | 1 | rd_data_o carries a result this cycle |
| stall_o | output | 1 | Processor must hold its current instruction |
| ovf_o | output | 1 | Sticky pointer overflow flag |
| cu_in_o | output | DEPTH*DATA_W | Whole input bank towards the compute unit |
| cu_start_o | output | 1 | One-cycle start pulse to the compute unit |
| cu_out_i | input | DEPTH*DATA_W | Whole result bank from the compute unit |

## Verification
The properties assume the processor issues at most one of move-to, execute or move-from per cycle. They also assume the processor keeps `mv_from_i` high for as long as `stall_o` is raised, and leaves the input bank alone while an operation is busy. The stimulus drives every request from a single sequential thread, one request per call. It waits out each stall before issuing the next request. It varies the latency and the number of staged argument pairs across all sixteen latency values, alternating blocking and concurrent executes. The compute unit is a stub whose output is a pure function of the input bank, so capture timing cannot alter the expected result.

// File: rtl/argbuf_pkg.sv
package argbuf_pkg;

   // which execute flavour owns the operation in flight
   typedef enum logic {
      MODE_CNC = 1'b0,
      MODE_BLK = 1'b1
   } exec_mode_e;

endpackage

// File: rtl/argbuf_ptr.sv
// Hidden pointer for one bank: clears to zero, steps by a fixed stride,
// and reports whether the next stride still fits inside the bank.
module argbuf_ptr #(
   parameter int DEPTH = 16,
   parameter int STEP  = 2,
   parameter int PW    = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          adv_i,
   output logic [PW-1:0] ptr_o,
   output logic          fits_o
);

   localparam logic [PW:0] STEP_X  = (PW+1)'(STEP);
   localparam logic [PW:0] DEPTH_X = (PW+1)'(DEPTH);

   always_ff @(posedge clk) begin
      if (!rst_n)     ptr_o <= '0;
      else if (clr_i) ptr_o <= '0;
      else if (adv_i) ptr_o <= ptr_o + STEP_X[PW-1:0];
   end

   assign fits_o = ({1'b0, ptr_o} + STEP_X) <= DEPTH_X;

endmodule

// File: rtl/argbuf_lat_timer.sv
// Down-counter that tracks one operation from start to capture.
module argbuf_lat_timer #(
   parameter int LAT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [LAT_W-1:0] lat_i,
   output logic             busy_o,
   output logic             fire_o,
   output logic             start_o
);

   logic [LAT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         busy_o  <= 1'b0;
         start_o <= 1'b0;
      end else begin
         start_o <= start_i;
         if (start_i) begin
            cnt_q  <= lat_i;
            busy_o <= 1'b1;
         end else if (fire_o) begin
            busy_o <= 1'b0;
         end else if (busy_o) begin
            cnt_q <= cnt_q - LAT_W'(1);
         end
      end
   end

   assign fire_o = busy_o && (cnt_q == '0);

endmodule

// File: rtl/argbuf_in_bank.sv
// Input register bank: PORTS words written per transfer at a base index,
// whole bank presented flat.
module argbuf_in_bank #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 16,
   parameter int PORTS  = 2,
   parameter int PW     = 5
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we_i,
   input  logic [PW-1:0]           base_i,
   input  logic [PORTS*DATA_W-1:0] wdata_i,
   output logic [DEPTH*DATA_W-1:0] bank_o
);

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic [DATA_W-1:0] ent_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent_q <= '0;
         end else if (we_i) begin
            for (int k = 0; k < PORTS; k++) begin
               if (({1'b0, base_i} + (PW+1)'(k)) == (PW+1)'(e))
                  ent_q <= wdata_i[k*DATA_W +: DATA_W];
            end
         end
      end

      assign bank_o[e*DATA_W +: DATA_W] = ent_q;
   end

endmodule

// File: rtl/arg_xfer_buffer.sv
module arg_xfer_buffer
   import argbuf_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int DEPTH    = 16,
   parameter int RD_PORTS = 2,
   parameter int WR_PORTS = 1,
   parameter int LAT_W    = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       mv_to_i,
   input  logic [RD_PORTS*DATA_W-1:0] mv_to_data_i,
   input  logic                       exec_blk_i,
   input  logic                       exec_cnc_i,
   input  logic [RD_PORTS*DATA_W-1:0] exec_src_i,
   input  logic [LAT_W-1:0]           exec_lat_i,
   input  logic                       mv_from_i,
   output logic [WR_PORTS*DATA_W-1:0] rd_data_o,
   output logic                       rd_valid_o,
   output logic                       stall_o,
   output logic                       ovf_o,
   output logic [DEPTH*DATA_W-1:0]    cu_in_o,
   output logic                       cu_start_o,
   input  logic [DEPTH*DATA_W-1:0]    cu_out_i
);

   localparam int PW = $clog2(DEPTH + 1);

   // elaboration-time parameter checks
   if (RD_PORTS < 1 || RD_PORTS > DEPTH) begin : g_bad_rd
      $error("RD_PORTS must lie in 1..DEPTH");
   end
   if (WR_PORTS < 1 || WR_PORTS > DEPTH) begin : g_bad_wr
      $error("WR_PORTS must lie in 1..DEPTH");
   end
   if (DATA_W < 1 || LAT_W < 1) begin : g_bad_w
      $error("DATA_W and LAT_W must be positive");
   end

   logic          busy, fire, exec_go, exec_req;
   logic          in_fits, out_fits, in_we, in_adv;
   logic          from_try, from_go, out_adv, ovf_set, blk_fire;
   logic [PW-1:0] in_ptr, out_ptr;
   exec_mode_e    mode_q;
   logic [RD_PORTS*DATA_W-1:0] in_wdata;
   logic [DATA_W-1:0]          out_bank [DEPTH];

   // request arbitration: execute, then move-to, then move-from
   assign exec_req = exec_blk_i | exec_cnc_i;
   assign exec_go  = exec_req && !busy;
   assign in_we    = (exec_go || mv_to_i) && in_fits;
   assign in_adv   = mv_to_i && !exec_go && in_fits;
   assign in_wdata = exec_go ? exec_src_i : mv_to_data_i;
   assign from_try = mv_from_i && !busy && !exec_go && !mv_to_i;
   assign from_go  = from_try && out_fits;
   assign blk_fire = fire && (mode_q == MODE_BLK);
   assign out_adv  = from_go || blk_fire;
   assign ovf_set  = ((exec_go || mv_to_i) && !in_fits) || (from_try && !out_fits);
   assign stall_o  = busy && ((mode_q == MODE_BLK) || mv_from_i);

   argbuf_ptr #(.DEPTH(DEPTH), .STEP(RD_PORTS), .PW(PW)) u_in_ptr (
      .clk(clk), .rst_n(rst_n), .clr_i(exec_go), .adv_i(in_adv),
      .ptr_o(in_ptr), .fits_o(in_fits)
   );

   argbuf_ptr #(.DEPTH(DEPTH), .STEP(WR_PORTS), .PW(PW)) u_out_ptr (
      .clk(clk), .rst_n(rst_n), .clr_i(exec_go), .adv_i(out_adv),
      .ptr_o(out_ptr), .fits_o(out_fits)
   );

   argbuf_lat_timer #(.LAT_W(LAT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .start_i(exec_go), .lat_i(exec_lat_i),
      .busy_o(busy), .fire_o(fire), .start_o(cu_start_o)
   );

   argbuf_in_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PORTS(RD_PORTS), .PW(PW)) u_in_bank (
      .clk(clk), .rst_n(rst_n), .we_i(in_we), .base_i(in_ptr),
      .wdata_i(in_wdata), .bank_o(cu_in_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)       mode_q <= MODE_CNC;
      else if (exec_go) mode_q <= exec_blk_i ? MODE_BLK : MODE_CNC;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        ovf_o <= 1'b0;
      else if (ovf_set)  ovf_o <= 1'b1;
   end

   // output bank: parallel capture on completion
   for (genvar e = 0; e < DEPTH; e++) begin : g_out
      always_ff @(posedge clk) begin
         if (!rst_n)    out_bank[e] <= '0;
         else if (fire) out_bank[e] <= cu_out_i[e*DATA_W +: DATA_W];
      end
   end

   // read-out lanes, one per register file write port
   for (genvar k = 0; k < WR_PORTS; k++) begin : g_rd
      logic [PW-1:0]     idx;
      logic [DATA_W-1:0] word;

      assign idx = out_ptr + PW'(k);

      always_comb begin
         word = '0;
         for (int e = 0; e < DEPTH; e++) begin
            if (idx == PW'(e)) word = out_bank[e];
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n)
            rd_data_o[k*DATA_W +: DATA_W] <= '0;
         else if (blk_fire)
            rd_data_o[k*DATA_W +: DATA_W] <= cu_out_i[k*DATA_W +: DATA_W];
         else if (from_go)
            rd_data_o[k*DATA_W +: DATA_W] <= word;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rd_valid_o <= 1'b0;
      else        rd_valid_o <= from_go || blk_fire;
   end

endmodule

// File: rtl/argbuf_chk.sv
module argbuf_chk #(
   parameter int RD_PORTS = 2,
   parameter int PW       = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mv_to_i,
   input logic          mv_from_i,
   input logic          exec_blk_i,
   input logic          exec_cnc_i,
   input logic          stall_o,
   input logic          rd_valid_o,
   input logic          ovf_o,
   input logic          busy,
   input logic          exec_go,
   input logic [PW-1:0] in_ptr,
   input logic [PW-1:0] out_ptr,
   input logic          in_fits,
   input logic          out_fits
);

   localparam logic [PW-1:0] RD_STEP = PW'(RD_PORTS);

   // R2: a fitting move-to steps the input pointer by the read port count
   a_r2_mvto_step: assert property (@(posedge clk) disable iff (!rst_n)
      (mv_to_i && !exec_go && in_fits) |=> (in_ptr == $past(in_ptr) + RD_STEP));

   // R3: an accepted execute leaves both pointers at zero
   a_r3_exec_clears: assert property (@(posedge clk) disable iff (!rst_n)
      exec_go |=> (in_ptr == '0 && out_ptr == '0));

   // R6: a concurrent execute alone never stalls
   a_r6_cnc_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_go && exec_cnc_i && !exec_blk_i) |=> (!stall_o || mv_from_i));

   // R7: an idle, fitting move-from returns data one cycle later
   a_r7_from_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (mv_from_i && !busy && !exec_go && !mv_to_i && out_fits) |=> rd_valid_o);

   // R8: the overflow flag never clears outside reset
   a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |=> ovf_o);

endmodule

bind arg_xfer_buffer argbuf_chk #(.RD_PORTS(RD_PORTS), .PW(PW)) u_chk (
   .clk(clk), .rst_n(rst_n), .mv_to_i(mv_to_i), .mv_from_i(mv_from_i),
   .exec_blk_i(exec_blk_i), .exec_cnc_i(exec_cnc_i), .stall_o(stall_o),
   .rd_valid_o(rd_valid_o), .ovf_o(ovf_o), .busy(busy), .exec_go(exec_go),
   .in_ptr(in_ptr), .out_ptr(out_ptr), .in_fits(in_fits), .out_fits(out_fits)
);

// File: tb/tb_arg_xfer_buffer.sv
module tb_arg_xfer_buffer;
   localparam int W = 32;
   localparam int D = 16;
   localparam int M = 2;
   localparam int N = 1;
   localparam int LW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mv_to_i = 1'b0, exec_blk_i = 1'b0, exec_cnc_i = 1'b0, mv_from_i = 1'b0;
   logic [M*W-1:0] mv_to_data_i = '0, exec_src_i = '0;
   logic [LW-1:0]  exec_lat_i = '0;
   logic [N*W-1:0] rd_data_o;
   logic rd_valid_o, stall_o, ovf_o, cu_start_o;
   logic [D*W-1:0] cu_in_o, cu_out_i;

   int errors = 0;
   int checks = 0;
   logic [31:0] m_in  [D];
   logic [31:0] m_out [D];
   int m_ip = 0;
   int m_op = 0;
   bit m_ovf = 0;

   always #5 clk = ~clk;

   arg_xfer_buffer #(.DATA_W(W), .DEPTH(D), .RD_PORTS(M), .WR_PORTS(N), .LAT_W(LW)) dut (
      .clk(clk), .rst_n(rst_n), .mv_to_i(mv_to_i), .mv_to_data_i(mv_to_data_i),
      .exec_blk_i(exec_blk_i), .exec_cnc_i(exec_cnc_i), .exec_src_i(exec_src_i),
      .exec_lat_i(exec_lat_i), .mv_from_i(mv_from_i), .rd_data_o(rd_data_o),
      .rd_valid_o(rd_valid_o), .stall_o(stall_o), .ovf_o(ovf_o),
      .cu_in_o(cu_in_o), .cu_start_o(cu_start_o), .cu_out_i(cu_out_i)
   );

   // compute unit stub: entry j = sum of all input entries + j
   always_comb begin
      logic [31:0] s;
      s = '0;
      for (int i = 0; i < D; i++) s = s + cu_in_o[i*W +: W];
      for (int j = 0; j < D; j++) cu_out_i[j*W +: W] = s + 32'(j);
   end

   function automatic logic [31:0] model_sum();
      logic [31:0] s = '0;
      for (int i = 0; i < D; i++) s = s + m_in[i];
      return s;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic chk_inbank(input string req);
      for (int i = 0; i < D; i++)
         chk(cu_in_o[i*W +: W] == m_in[i], req, "input bank entry",
             cu_in_o[i*W +: W], m_in[i]);
   endtask

   task automatic mv_to(input logic [31:0] a, input logic [31:0] b);
      mv_to_i = 1'b1;
      mv_to_data_i = {b, a};
      @(negedge clk);
      mv_to_i = 1'b0;
      if (m_ip + M <= D) begin
         m_in[m_ip] = a;
         m_in[m_ip+1] = b;
         m_ip += M;
      end else begin
         m_ovf = 1;
      end
   endtask

   task automatic exec_op(input bit blk, input logic [31:0] a, input logic [31:0] b,
                          input int lat);
      int n;
      exec_blk_i = blk;
      exec_cnc_i = !blk;
      exec_src_i = {b, a};
      exec_lat_i = LW'(lat);
      @(negedge clk);
      exec_blk_i = 1'b0;
      exec_cnc_i = 1'b0;
      if (m_ip + M <= D) begin
         m_in[m_ip] = a;
         m_in[m_ip+1] = b;
      end else begin
         m_ovf = 1;
      end
      m_ip = 0;
      m_op = 0;
      for (int j = 0; j < D; j++) m_out[j] = model_sum() + 32'(j);
      chk(cu_start_o == 1'b1, "R4", "start pulse", 32'(cu_start_o), 1);
      chk_inbank("R3");
      if (blk) begin
         n = 0;
         while (stall_o && n < 100) begin
            @(negedge clk);
            n++;
         end
         chk(n == lat + 1, "R5", "blocking stall cycles", n, lat + 1);
         chk(rd_valid_o == 1'b1, "R5", "blocking result valid", 32'(rd_valid_o), 1);
         chk(rd_data_o == m_out[0], "R5", "blocking result data", rd_data_o, m_out[0]);
         m_op = N;
      end else begin
         chk(stall_o == 1'b0, "R6", "concurrent execute stall", 32'(stall_o), 0);
      end
   endtask

   task automatic mv_from(input int exp_stall);
      int n;
      mv_from_i = 1'b1;
      #1;
      n = 0;
      while (stall_o && n < 100) begin
         @(negedge clk);
         #1;
         n++;
      end
      chk(n == exp_stall, "R7", "move-from stall cycles", n, exp_stall);
      @(negedge clk);
      mv_from_i = 1'b0;
      if (m_op + N <= D) begin
         chk(rd_valid_o == 1'b1, "R7", "move-from valid", 32'(rd_valid_o), 1);
         chk(rd_data_o == m_out[m_op], "R7", "move-from data", rd_data_o, m_out[m_op]);
         m_op += N;
      end else begin
         m_ovf = 1;
         chk(rd_valid_o == 1'b0, "R8", "dropped move-from valid", 32'(rd_valid_o), 0);
         chk(ovf_o == 1'b1, "R8", "overflow after move-from", 32'(ovf_o), 1);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < D; i++) begin
         m_in[i] = '0;
         m_out[i] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(stall_o == 1'b0, "R1", "stall after reset", 32'(stall_o), 0);
      chk(rd_valid_o == 1'b0, "R1", "valid after reset", 32'(rd_valid_o), 0);
      chk(ovf_o == 1'b0, "R1", "overflow after reset", 32'(ovf_o), 0);
      chk(cu_start_o == 1'b0, "R1", "start after reset", 32'(cu_start_o), 0);
      chk_inbank("R1");

      // sweep every latency, with varying staged argument counts
      for (int lat = 0; lat < 16; lat++) begin
         for (int k = 0; k < lat % 6; k++)
            mv_to(32'(lat*1000 + k*2 + 1), 32'(lat*1000 + k*2 + 2));
         chk_inbank("R2");
         exec_op(lat % 2 == 0, 32'h0000_A000 + 32'(lat), 32'h0000_B000 + 32'(lat), lat);
         if (lat % 2 == 0) begin
            mv_from(0);
            mv_from(0);
         end else begin
            mv_from(lat + 1);
            mv_from(0);
            mv_from(0);
         end
      end

      // R4: execute arriving while busy is ignored
      exec_op(1'b0, 32'd1, 32'd2, 9);
      repeat (2) @(negedge clk);
      exec_blk_i = 1'b1;
      exec_src_i = {32'd88, 32'd77};
      exec_lat_i = LW'(1);
      #1;
      chk(stall_o == 1'b0, "R4", "stall from ignored execute", 32'(stall_o), 0);
      @(negedge clk);
      exec_blk_i = 1'b0;
      chk(cu_start_o == 1'b0, "R4", "no start for ignored execute", 32'(cu_start_o), 0);
      chk_inbank("R4");
      mv_from(7);

      // R8: exact fill is fine, one more transfer is dropped
      for (int k = 0; k < D / M; k++) mv_to(32'(500 + k*2), 32'(501 + k*2));
      chk(ovf_o == 1'b0, "R8", "overflow at exact fill", 32'(ovf_o), 0);
      chk_inbank("R8");
      mv_to(32'hDEAD_0001, 32'hDEAD_0002);
      chk(ovf_o == 1'b1, "R8", "overflow after extra move-to", 32'(ovf_o), 1);
      chk_inbank("R8");
      exec_op(1'b1, 32'hBEEF_0001, 32'hBEEF_0002, 2);
      for (int k = 1; k < D; k++) mv_from(0);
      mv_from(0);
      repeat (3) @(negedge clk);
      chk(ovf_o == 1'b1, "R8", "overflow stays set", 32'(ovf_o), 1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule